// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

A clocked controller that turns one-at-a-time host read and write requests into the control strobes and data bus activity for an external asynchronous SRAM. The SRAM is built from four 8-bit-wide banks of 512K locations. Each bank has its own active-low chip select and write enable. All four banks share one active-low output enable and one address bus. The controller also drives a bidirectional data bus through a separate drive-enable signal.

A static two-bit input sets how the four banks are organised:

- **32-bit mode.** All four banks act as one word-wide bank, and each byte lane has its own write strobe.
- **16-bit mode.** The banks form two halfword banks.
- **8-bit mode.** The banks form four independent byte banks.

In the two narrow modes, the two low host address bits choose the bank. Read data is returned right-aligned on the host bus.

Every timing phase is a compile-time count of clock cycles. A write has a setup phase, a pulse phase and a hold phase. A read has an access phase, and the controller can then idle for a set number of turnaround cycles. Writes are shaped by the overlap of chip select and write enable. Write enable drops only after chip select and the address have settled, and it rises before chip select and the data are released.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, every chip select, every write enable and the output enable are high, the data bus is not driven, `ready_o` is 1 and `rvalid_o` is 0.
- R2: In a write that strobes at least one lane:
  - chip select and the address are active for T_SETUP cycles before any write enable falls;
  - write enables stay low for exactly T_PULSE cycles;
  - chip select stays low for T_HOLD cycles after the write enables rise;
  - output enable stays high throughout the write.
- R3: Write data is driven from the first setup cycle through the last hold cycle and is stable during that time. The bus is never driven during a read or while idle.
- R4: A read holds chip select and output enable low, with every write enable high, for T_ACCESS+1 cycles. The bus is sampled in the last of those cycles. `rvalid_o` is high for exactly one cycle, the cycle after that, and carries the sampled data.
- R5: After a read, the controller spends T_TURN cycles with all strobes inactive before `ready_o` returns to 1.
- R6: Mode 2'b00 (32-bit):
  - all four chip selects are asserted;
  - `be_i[k]` drives write enable k, which writes data bits 8k+7..8k, taken from the same `wdata_i` bits;
  - with `be_i` = 0 no write enable falls;
  - a read returns all 32 bits.
- R7: Mode 2'b01 (16-bit):
  - host address bit 1 picks the bank: 0 selects chip selects 1:0 and bus bits 15:0, and 1 selects chip selects 3:2 and bus bits 31:16;
  - `be_i[1:0]` picks the low and high byte within that bank;
  - `wdata_i[15:0]` appears on the selected bank's lanes;
  - a read returns that bank's 16 bits zero-extended.
- R8: Modes 2'b10 and 2'b11 (8-bit):
  - host address bits 1:0 pick one lane, which uses that chip select and that write enable regardless of `be_i`;
  - `wdata_i[7:0]` appears on that lane;
  - a read returns that lane's byte zero-extended.
- R9: A chip select that the current mode and bank do not use stays high for the whole access.
- R10: The SRAM address equals host address bits 20:2 and does not change while any chip select is low.
- R11: `ready_o` is low from the cycle after a request is accepted until the access ends. A write lasts T_SETUP+T_PULSE+T_HOLD cycles, and a read lasts T_ACCESS+1+T_TURN cycles.
- R12: Output enable is never low together with a low write enable, nor while the controller drives the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bank organisation: 00 word, 01 halfword, 1x byte |
| req_i | input | 1 | Access request, taken when `ready_o` is 1 |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 21 | Host address; bits 1:0 choose the lane or bank |
| be_i | input | 4 | Byte write mask (32-bit mode all bits, 16-bit mode bits 1:0) |
| wdata_i | input | 32 | Write data, right-aligned in the narrow modes |
| ready_o | output | 1 | Controller idle and able to take a request |
| rvalid_o | output | 1 | One-cycle read-data strobe |
| rdata_o | output | 32 | Read data, right-aligned and zero-extended |
| sram_addr_o | output | 19 | SRAM address |
| sram_cs_no | output | 4 | Per-bank chip selects, active low |
| sram_we_no | output | 4 | Per-bank write enables, active low |
| sram_oe_no | output | 1 | Shared output enable, active low |
| sram_dq_o | output | 32 | Data driven toward the SRAM |
| sram_dq_i | input | 32 | Data returned by the SRAM |
| sram_dq_oe_o | output | 1 | Drive enable for the data bus pads |

## Verification
Several properties are checked on every cycle:
- a low write enable always sits inside a low chip select on its lane;
- write enable falls only after chip select has settled;
- output enable never overlaps a write strobe or host drive on the bus;
- the address and the driven data stay stable while they are in use;
- unused chip selects stay high in the narrow modes;
- the read strobe is a single-cycle pulse.

Other behaviour can only be shown by the bench's scenarios:
- the exact phase lengths;
- which lanes get strobed for a given mode, bank and byte mask;
- the data written into and read back from a model SRAM;
- the turnaround gap after a read.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  localparam logic [1:0] ORG_W32 = 2'b00;
  localparam logic [1:0] ORG_W16 = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RCAP,
    ST_TURN
  } ctrl_state_e;
endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  assert_cnt_floor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/lane_map.sv
module lane_map
  import sram_lane_pkg::*;
#(
  parameter int LW = 8,
  localparam int NL = 4,
  localparam int DW = NL * LW
) (
  input  logic [1:0]    mode_i,
  input  logic [1:0]    lane_sel_i,
  input  logic [NL-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  output logic [NL-1:0] cs_mask_o,
  output logic [NL-1:0] we_mask_o,
  output logic [DW-1:0] wbus_o
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic          sel;
    logic          wen;
    logic [LW-1:0] wb;

    always_comb begin
      case (mode_i)
        ORG_W32: begin
          sel = 1'b1;
          wen = be_i[l];
          wb  = wdata_i[l*LW +: LW];
        end
        ORG_W16: begin
          sel = (lane_sel_i[1] == (l >= 2));
          wen = sel & be_i[l % 2];
          wb  = wdata_i[(l % 2)*LW +: LW];
        end
        default: begin
          sel = (lane_sel_i == 2'(l));
          wen = sel;
          wb  = wdata_i[LW-1:0];
        end
      endcase
    end

    assign cs_mask_o[l]         = sel;
    assign we_mask_o[l]         = wen;
    assign wbus_o[l*LW +: LW]   = wb;
  end
endmodule

// File: rtl/rd_align.sv
module rd_align
  import sram_lane_pkg::*;
#(
  parameter int LW = 8,
  localparam int DW = 4 * LW
) (
  input  logic [1:0]    mode_i,
  input  logic [1:0]    lane_sel_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (mode_i)
      ORG_W32: rdata_o = dq_i;
      ORG_W16: rdata_o[2*LW-1:0] = lane_sel_i[1] ? dq_i[DW-1:2*LW] : dq_i[2*LW-1:0];
      default: rdata_o[LW-1:0]   = dq_i[lane_sel_i*LW +: LW];
    endcase
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int AW       = 19,
  parameter int LW       = 8,
  parameter int T_SETUP  = 1,
  parameter int T_PULSE  = 1,
  parameter int T_HOLD   = 1,
  parameter int T_ACCESS = 2,
  parameter int T_TURN   = 1,
  localparam int DW      = 4 * LW,
  localparam int HAW     = AW + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     mode_i,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [HAW-1:0] addr_i,
  input  logic [3:0]     be_i,
  input  logic [DW-1:0]  wdata_i,
  output logic           ready_o,
  output logic           rvalid_o,
  output logic [DW-1:0]  rdata_o,
  output logic [AW-1:0]  sram_addr_o,
  output logic [3:0]     sram_cs_no,
  output logic [3:0]     sram_we_no,
  output logic           sram_oe_no,
  output logic [DW-1:0]  sram_dq_o,
  input  logic [DW-1:0]  sram_dq_i,
  output logic           sram_dq_oe_o
);
  localparam int M1   = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int M2   = (T_HOLD > T_ACCESS) ? T_HOLD : T_ACCESS;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXT = (M3 > T_TURN) ? M3 : T_TURN;
  localparam int CW   = $clog2(MAXT + 1);
  localparam int TURN_LD = (T_TURN > 0) ? T_TURN - 1 : 0;

  ctrl_state_e   st_q, st_d;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          t_done;

  logic [AW-1:0] addr_q;
  logic [1:0]    lane_q, org_q;
  logic [3:0]    cs_q, we_q;
  logic [DW-1:0] wbus_q, rdata_q;
  logic          rvalid_q;

  logic [3:0]    map_cs, map_we;
  logic [DW-1:0] map_wbus, rd_aligned;

  lane_map #(.LW(LW)) u_map (
    .mode_i     (mode_i),
    .lane_sel_i (addr_i[1:0]),
    .be_i       (be_i),
    .wdata_i    (wdata_i),
    .cs_mask_o  (map_cs),
    .we_mask_o  (map_we),
    .wbus_o     (map_wbus)
  );

  rd_align #(.LW(LW)) u_align (
    .mode_i     (org_q),
    .lane_sel_i (lane_q),
    .dq_i       (sram_dq_i),
    .rdata_o    (rd_aligned)
  );

  phase_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .done_o (t_done)
  );

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        ld = 1'b1;
        if (we_i) begin
          st_d   = ST_WSETUP;
          ld_val = CW'(T_SETUP - 1);
        end else begin
          st_d   = ST_RACC;
          ld_val = CW'(T_ACCESS - 1);
        end
      end
      ST_WSETUP: if (t_done) begin
        st_d = ST_WPULSE; ld = 1'b1; ld_val = CW'(T_PULSE - 1);
      end
      ST_WPULSE: if (t_done) begin
        st_d = ST_WHOLD; ld = 1'b1; ld_val = CW'(T_HOLD - 1);
      end
      ST_WHOLD: if (t_done) st_d = ST_IDLE;
      ST_RACC:  if (t_done) st_d = ST_RCAP;
      ST_RCAP: begin
        if (T_TURN > 0) begin
          st_d = ST_TURN; ld = 1'b1; ld_val = CW'(TURN_LD);
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_TURN: if (t_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      lane_q   <= '0;
      org_q    <= ORG_W32;
      cs_q     <= '0;
      we_q     <= '0;
      wbus_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      rvalid_q <= (st_q == ST_RCAP);
      if (st_q == ST_RCAP) rdata_q <= rd_aligned;
      if (st_q == ST_IDLE && req_i) begin
        addr_q <= addr_i[HAW-1:2];
        lane_q <= addr_i[1:0];
        org_q  <= mode_i;
        cs_q   <= map_cs;
        we_q   <= we_i ? map_we : '0;
        wbus_q <= map_wbus;
      end
    end
  end

  logic wr_phase, rd_phase;
  assign wr_phase = (st_q == ST_WSETUP) || (st_q == ST_WPULSE) || (st_q == ST_WHOLD);
  assign rd_phase = (st_q == ST_RACC) || (st_q == ST_RCAP);

  assign ready_o      = (st_q == ST_IDLE);
  assign rvalid_o     = rvalid_q;
  assign rdata_o      = rdata_q;
  assign sram_addr_o  = addr_q;
  assign sram_cs_no   = (wr_phase || rd_phase) ? ~cs_q : '1;
  assign sram_we_no   = (st_q == ST_WPULSE) ? ~we_q : '1;
  assign sram_oe_no   = ~rd_phase;
  assign sram_dq_o    = wbus_q;
  assign sram_dq_oe_o = wr_phase;

  assert_we_inside_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~sram_we_no) & sram_cs_no) == 4'b0000);

  assert_we_after_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_we_no != 4'hF && $past(sram_we_no) == 4'hF) |-> ($past(sram_cs_no) == sram_cs_no));

  assert_wdata_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));

  assert_rvalid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  assert_byte_one_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (org_q[1] && sram_cs_no != 4'hF) |-> ($countones(~sram_cs_no) == 1));

  assert_half_pair_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (org_q == ORG_W16 && sram_cs_no != 4'hF) |-> (sram_cs_no == 4'b1100 || sram_cs_no == 4'b0011));

  assert_addr_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_cs_no != 4'hF && $past(sram_cs_no) != 4'hF) |-> $stable(sram_addr_o));

  assert_busy_after_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i) |=> !ready_o);

  assert_oe_not_with_we_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> (sram_we_no == 4'hF));

  assert_oe_not_with_drive_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);
endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
  localparam int TS = 2, TP = 3, TH = 1, TA = 2, TT = 2;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        req = 1'b0, we = 1'b0;
  logic [20:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        ready, rvalid;
  logic [31:0] rdata;
  logic [18:0] s_addr;
  logic [3:0]  s_cs, s_we;
  logic        s_oe, s_dqoe;
  logic [31:0] s_dqo, s_dqi;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] sram_mem [256];
  logic [31:0] exp_mem  [256];

  always #5 clk = ~clk;

  sram_lane_ctrl #(.T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .T_ACCESS(TA), .T_TURN(TT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata),
    .sram_addr_o(s_addr), .sram_cs_no(s_cs), .sram_we_no(s_we), .sram_oe_no(s_oe),
    .sram_dq_o(s_dqo), .sram_dq_i(s_dqi), .sram_dq_oe_o(s_dqoe));

  // model SRAM: write during cs&we overlap, read when cs&oe low and we high
  always @(negedge clk)
    for (int l = 0; l < 4; l++)
      if (!s_cs[l] && !s_we[l]) sram_mem[s_addr[7:0]][8*l +: 8] <= s_dqo[8*l +: 8];

  always_comb
    for (int l = 0; l < 4; l++)
      s_dqi[8*l +: 8] = (!s_cs[l] && !s_oe && s_we[l]) ? sram_mem[s_addr[7:0]][8*l +: 8] : 8'h5A;

  function automatic logic [3:0] f_cs(logic [1:0] m, logic [20:0] a);
    case (m)
      2'b00:   return 4'hF;
      2'b01:   return a[1] ? 4'hC : 4'h3;
      default: return 4'b0001 << a[1:0];
    endcase
  endfunction

  function automatic logic [3:0] f_we(logic [1:0] m, logic [20:0] a, logic [3:0] b);
    case (m)
      2'b00:   return b;
      2'b01:   return a[1] ? {b[1:0], 2'b00} : {2'b00, b[1:0]};
      default: return 4'b0001 << a[1:0];
    endcase
  endfunction

  function automatic logic [7:0] f_lane(logic [1:0] m, logic [31:0] d, int l);
    case (m)
      2'b00:   return d[8*l +: 8];
      2'b01:   return d[8*(l%2) +: 8];
      default: return d[7:0];
    endcase
  endfunction

  function automatic logic [31:0] f_rd(logic [1:0] m, logic [20:0] a, logic [31:0] w);
    case (m)
      2'b00:   return w;
      2'b01:   return {16'h0, a[1] ? w[31:16] : w[15:0]};
      default: return {24'h0, w[8*a[1:0] +: 8]};
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(logic [1:0] m, bit w, logic [20:0] a, logic [3:0] b, logic [31:0] d);
    int setup_n = 0, pulse_n = 0, hold_n = 0, act_n = 0, turn_n = 0, total = 0, drv_n = 0;
    bit seen_we = 0, oe_bad = 0, we_bad = 0, mask_ok = 1, addr_ok = 1, got_rv = 0, drv_bad = 0;
    logic [3:0]  ecs = f_cs(m, a);
    logic [3:0]  ewe = f_we(m, a, b);
    logic [31:0] rv = '0;
    logic [7:0]  idx = a[9:2];
    @(negedge clk);
    mode = m; req = 1'b1; we = w; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0;
    while (!ready && total < 100) begin
      total++;
      if (rvalid) begin got_rv = 1; rv = rdata; end
      if (s_cs != 4'hF) begin
        if (~s_cs != ecs) mask_ok = 0;
        if (s_addr != a[20:2]) addr_ok = 0;
      end
      if (w) begin
        if (!s_oe) oe_bad = 1;
        if (s_dqoe) drv_n++;
        if (s_we != 4'hF) begin
          seen_we = 1; pulse_n++;
          if (~s_we != ewe) we_bad = 1;
          for (int l = 0; l < 4; l++)
            if (ewe[l] && s_dqo[8*l +: 8] != f_lane(m, d, l)) we_bad = 1;
        end else if (s_cs != 4'hF) begin
          if (seen_we) hold_n++; else setup_n++;
        end
      end else begin
        if (s_dqoe) drv_bad = 1;
        if (s_cs != 4'hF) begin
          act_n++;
          if (s_oe || s_we != 4'hF) oe_bad = 1;
        end else turn_n++;
      end
      @(negedge clk);
    end
    if (rvalid) begin got_rv = 1; rv = rdata; end
    chk(mask_ok, "R9 chip-select mask", {28'h0, ecs}, {28'h0, ecs});
    chk(addr_ok, "R10 sram address", {13'h0, s_addr}, {13'h0, a[20:2]});
    if (w) begin
      chk(total == TS + TP + TH, "R11 write length", total, TS + TP + TH);
      chk(!oe_bad, "R2 oe high in write", oe_bad, 0);
      chk(drv_n == TS + TP + TH, "R3 write drive span", drv_n, TS + TP + TH);
      if (ewe != 4'h0) begin
        chk(setup_n == TS, "R2 setup cycles", setup_n, TS);
        chk(pulse_n == TP, "R2 pulse cycles", pulse_n, TP);
        chk(hold_n == TH, "R2 hold cycles", hold_n, TH);
        chk(!we_bad, "R6/R7/R8 strobe lanes and data", {28'h0, ~s_we}, {28'h0, ewe});
      end else begin
        chk(pulse_n == 0, "R6 zero mask strobes nothing", pulse_n, 0);
      end
      for (int l = 0; l < 4; l++)
        if (ewe[l]) exp_mem[idx][8*l +: 8] = f_lane(m, d, l);
    end else begin
      chk(total == TA + 1 + TT, "R11 read length", total, TA + 1 + TT);
      chk(act_n == TA + 1, "R4 access cycles", act_n, TA + 1);
      chk(turn_n == TT, "R5 turnaround cycles", turn_n, TT);
      chk(!oe_bad && !drv_bad, "R4 read strobes / R3 no drive", {oe_bad, drv_bad}, 0);
      chk(got_rv && rv == f_rd(m, a, exp_mem[idx]), "R4/R6/R7/R8 read data", rv, f_rd(m, a, exp_mem[idx]));
    end
    chk(!rvalid && s_cs == 4'hF && s_oe && s_we == 4'hF && !s_dqoe, "R1 idle after access",
        {s_cs, s_we, 22'h0, s_oe, s_dqoe}, {8'hFF, 22'h0, 2'b10});
  endtask

  function automatic logic [20:0] mk_addr(logic [7:0] i, logic [1:0] lane);
    return {11'h0, i, lane};
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'd7741);
    for (int i = 0; i < 256; i++) begin sram_mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    chk(ready && !rvalid && s_cs == 4'hF && s_we == 4'hF && s_oe && !s_dqoe, "R1 reset state",
        {ready, rvalid, s_cs, s_we, s_oe, s_dqoe}, 32'h00000BFE);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ready && s_cs == 4'hF, "R1 idle after reset", {ready, s_cs}, 5'h1F);

    do_op(2'b00, 1, mk_addr(8'd1, 2'd0), 4'hF, 32'hA1B2C3D4);
    do_op(2'b00, 0, mk_addr(8'd1, 2'd0), 4'h0, 32'h0);
    do_op(2'b00, 1, mk_addr(8'd1, 2'd0), 4'h0, 32'hFFFFFFFF); // R6 zero mask
    do_op(2'b00, 0, mk_addr(8'd1, 2'd0), 4'h0, 32'h0);
    do_op(2'b00, 1, mk_addr(8'd1, 2'd0), 4'b0101, 32'h11223344);
    do_op(2'b00, 0, mk_addr(8'd1, 2'd0), 4'h0, 32'h0);
    do_op(2'b01, 1, mk_addr(8'd2, 2'd2), 4'h3, 32'h0000BEEF); // R7 upper bank
    do_op(2'b01, 1, mk_addr(8'd2, 2'd0), 4'h2, 32'h00007700); // R7 high byte only
    do_op(2'b01, 0, mk_addr(8'd2, 2'd2), 4'h0, 32'h0);
    do_op(2'b01, 0, mk_addr(8'd2, 2'd0), 4'h0, 32'h0);
    do_op(2'b10, 1, mk_addr(8'd3, 2'd3), 4'h0, 32'h000000C7); // R8 lane 3, be ignored
    do_op(2'b11, 1, mk_addr(8'd3, 2'd1), 4'h0, 32'h0000005E); // R8 mode 11
    do_op(2'b11, 0, mk_addr(8'd3, 2'd3), 4'h0, 32'h0);
    do_op(2'b00, 0, mk_addr(8'd3, 2'd0), 4'h0, 32'h0);

    for (int k = 0; k < 400; k++) begin
      logic [1:0] m   = 2'($urandom % 4);
      bit         w   = 1'($urandom % 2);
      logic [7:0] i   = 8'($urandom % 16);
      logic [1:0] ln  = 2'($urandom % 4);
      logic [3:0] b   = 4'($urandom % 16);
      do_op(m, w, mk_addr(i, ln), b, $urandom);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R11 act=%h exp=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule